// File: doc/BRIEF.md
# DRAM Clock-Stop Permission Controller

This block sits inside a low-power DRAM controller and decides when the memory clock may be halted or retuned to another frequency. It watches every command the controller issues, the read data-out burst indicator and the clock-enable level. Each command that opens a timing window loads a down-counter, and the block tracks each read until its data-out burst has ended.

Permission is granted only when all window counters are zero, no read is still open, no command is being issued in the current cycle, the clock-enable is high and no refresh is due. The same qualification gates frequency changes. When the controller asks to stop and permission holds, the block parks the differential clock at its idle level: true phase low, complement high. A wake request, or a refresh falling due, restarts the clock. The clock then runs for a set number of cycles before new commands are accepted again.

Top module: `ckstop_guard`

## Requirements
- R1: Command codes on `cmdCode` (3 bits) are 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 mode-register load; 0 and 7 have no effect. Each of these opens a timing window: activate (RCD_CYC), write (WR_CYC), precharge (RP_CYC), refresh (RFC_CYC) and mode-register load (MRD_CYC). A command opening a window holds `stopAllowed` low for exactly that many cycles after the edge at which it was sampled.
- R2: After a read command, `stopAllowed` stays low until `rdBurstActive` has been seen high and has then returned low. It rises in the first cycle in which the burst indicator is low again.
- R3: `stopAllowed` is low in any cycle in which `cmdValid` is high.
- R4: `stopAllowed` is low whenever `ckeHigh` is low.
- R5: `stopAllowed` is low whenever `refreshDue` is high.
- R6: `freqChangeOk` always equals `stopAllowed`.
- R7: If `stopReq` and `stopAllowed` are both high at a clock edge, `clkStopped` is high from the next cycle. While stopped, `ckOut` is 0, `ckbOut` is 1 and `cmdReady` is 0.
- R8: A `stopReq` while `stopAllowed` is low has no effect: the clock keeps toggling and `clkStopped` stays low.
- R9: While stopped, `refreshDue` drives `restartReq` high in the same cycle, and the clock restarts from the next edge.
- R10: After a wake (`wakeReq` or a refresh while stopped), `cmdReady` stays low for exactly WAKE_CYC cycles while the clock toggles, then returns high.
- R11: After reset the clock is running (`clkStopped` 0), `cmdReady` is 1 and `restartReq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A command is issued this cycle |
| cmdCode | input | 3 | Command type (encoding in R1) |
| rdBurstActive | input | 1 | Read data-out burst in progress |
| ckeHigh | input | 1 | Current clock-enable level |
| refreshDue | input | 1 | A refresh is pending |
| stopReq | input | 1 | Request to stop the memory clock |
| wakeReq | input | 1 | Request to restart the memory clock |
| stopAllowed | output | 1 | All clock-stop conditions hold |
| freqChangeOk | output | 1 | Frequency change permitted |
| clkStopped | output | 1 | Memory clock is parked |
| restartReq | output | 1 | Refresh requires the clock back |
| cmdReady | output | 1 | New commands may be issued |
| ckOut | output | 1 | Memory clock, true phase |
| ckbOut | output | 1 | Memory clock, complement phase |

## Verification
The window logic is exercised by issuing each command type on its own and counting the cycles for which permission stays low. A wrong window length or a command mapped to the wrong counter shows up as a miscounted row. The read row places the burst after a delay, so an implementation that releases at the read command, or at the burst start, is told apart from one that waits for the burst to end. Directed sequences then try stop requests with and without permission, clock-enable low, refresh arriving before and during a stop, and a wake request. Together these separate gating mistakes, a wrong idle clock level and a wrong wake hold-off length.

// File: rtl/ckstop_pkg.sv
package ckstop_pkg;
  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_REF  = 3'd5,
    CMD_MRS  = 3'd6
  } cmd_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_WAKE = 2'd2
  } state_e;

  typedef struct packed {
    logic loadWake;
    logic clkRun;
  } strobe_t;
endpackage

// File: rtl/ckstop_datapath.sv
module ckstop_datapath
  import ckstop_pkg::*;
#(
  parameter int RCD_CYC  = 3,
  parameter int WR_CYC   = 5,
  parameter int RP_CYC   = 4,
  parameter int RFC_CYC  = 8,
  parameter int MRD_CYC  = 2,
  parameter int WAKE_CYC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdCode,
  input  logic       rdBurstActive,
  input  strobe_t    strobe,
  output logic       timersIdle,
  output logic       rdOpen,
  output logic       wakeLast,
  output logic       ckOut,
  output logic       ckbOut
);
  localparam int NWIN = 5;
  localparam int WIN_CYC [NWIN] = '{RCD_CYC, WR_CYC, RP_CYC, RFC_CYC, MRD_CYC};
  localparam int WIN_CODE[NWIN] = '{int'(CMD_ACT), int'(CMD_WR), int'(CMD_PRE),
                                    int'(CMD_REF), int'(CMD_MRS)};
  localparam int MAX_A   = (RCD_CYC > WR_CYC) ? RCD_CYC : WR_CYC;
  localparam int MAX_B   = (RP_CYC > RFC_CYC) ? RP_CYC : RFC_CYC;
  localparam int MAX_C   = (MRD_CYC > WAKE_CYC) ? MRD_CYC : WAKE_CYC;
  localparam int MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_ALL = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
  localparam int CNT_W   = $clog2(MAX_ALL + 1);

  logic [NWIN-1:0] winBusy;

  // one down-counter per timing window
  for (genvar g = 0; g < NWIN; g++) begin : g_win
    logic [CNT_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt <= '0;
      end else if (cmdValid && (cmdCode == 3'(WIN_CODE[g]))) begin
        cnt <= CNT_W'(WIN_CYC[g]);
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
    assign winBusy[g] = (cnt != '0);
  end

  assign timersIdle = (winBusy == '0);

  // read tracking: open from the read command until its burst has ended
  logic rdPending, burstSeen;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPending <= 1'b0;
      burstSeen <= 1'b0;
    end else if (cmdValid && (cmdCode == 3'(CMD_RD))) begin
      rdPending <= 1'b1;
      burstSeen <= 1'b0;
    end else if (rdPending) begin
      if (rdBurstActive) begin
        burstSeen <= 1'b1;
      end else if (burstSeen) begin
        rdPending <= 1'b0;
        burstSeen <= 1'b0;
      end
    end
  end
  assign rdOpen = rdPending && !(burstSeen && !rdBurstActive);

  // wake hold-off counter
  logic [CNT_W-1:0] wakeCnt;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wakeCnt <= '0;
    end else if (strobe.loadWake) begin
      wakeCnt <= CNT_W'(WAKE_CYC);
    end else if (wakeCnt != '0) begin
      wakeCnt <= wakeCnt - 1'b1;
    end
  end
  assign wakeLast = (wakeCnt == CNT_W'(1));

  // memory clock: toggles while running, parked low when stopped
  logic ckPhase;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ckPhase <= 1'b0;
    end else if (strobe.clkRun) begin
      ckPhase <= ~ckPhase;
    end else begin
      ckPhase <= 1'b0;
    end
  end
  assign ckOut  = ckPhase;
  assign ckbOut = ~ckPhase;
endmodule

// File: rtl/ckstop_control.sv
module ckstop_control
  import ckstop_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdValid,
  input  logic    ckeHigh,
  input  logic    refreshDue,
  input  logic    stopReq,
  input  logic    wakeReq,
  input  logic    timersIdle,
  input  logic    rdOpen,
  input  logic    wakeLast,
  output strobe_t strobe,
  output logic    stopAllowed,
  output logic    freqChangeOk,
  output logic    clkStopped,
  output logic    restartReq,
  output logic    cmdReady
);
  state_e state, stateNext;
  logic   qualified;

  assign qualified = timersIdle && !rdOpen && !cmdValid && ckeHigh && !refreshDue;

  always_comb begin
    stateNext       = state;
    strobe.loadWake = 1'b0;
    unique case (state)
      ST_RUN:  if (stopReq && qualified) stateNext = ST_STOP;
      ST_STOP: if (wakeReq || refreshDue) begin
                 stateNext       = ST_WAKE;
                 strobe.loadWake = 1'b1;
               end
      ST_WAKE: if (wakeLast) stateNext = ST_RUN;
      default: stateNext = ST_RUN;
    endcase
    strobe.clkRun = (stateNext != ST_STOP);
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  assign stopAllowed  = qualified && (state == ST_RUN);
  assign freqChangeOk = qualified && (state == ST_RUN);
  assign clkStopped   = (state == ST_STOP);
  assign restartReq   = (state == ST_STOP) && refreshDue;
  assign cmdReady     = (state == ST_RUN);
endmodule

// File: rtl/ckstop_guard.sv
module ckstop_guard
  import ckstop_pkg::*;
#(
  parameter int RCD_CYC  = 3,
  parameter int WR_CYC   = 5,
  parameter int RP_CYC   = 4,
  parameter int RFC_CYC  = 8,
  parameter int MRD_CYC  = 2,
  parameter int WAKE_CYC = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdCode,
  input  logic       rdBurstActive,
  input  logic       ckeHigh,
  input  logic       refreshDue,
  input  logic       stopReq,
  input  logic       wakeReq,
  output logic       stopAllowed,
  output logic       freqChangeOk,
  output logic       clkStopped,
  output logic       restartReq,
  output logic       cmdReady,
  output logic       ckOut,
  output logic       ckbOut
);
  strobe_t strobe;
  logic    timersIdle, rdOpen, wakeLast;

  ckstop_datapath #(
    .RCD_CYC(RCD_CYC), .WR_CYC(WR_CYC), .RP_CYC(RP_CYC),
    .RFC_CYC(RFC_CYC), .MRD_CYC(MRD_CYC), .WAKE_CYC(WAKE_CYC)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .rdBurstActive(rdBurstActive), .strobe(strobe),
    .timersIdle(timersIdle), .rdOpen(rdOpen), .wakeLast(wakeLast),
    .ckOut(ckOut), .ckbOut(ckbOut)
  );

  ckstop_control control_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .ckeHigh(ckeHigh),
    .refreshDue(refreshDue), .stopReq(stopReq), .wakeReq(wakeReq),
    .timersIdle(timersIdle), .rdOpen(rdOpen), .wakeLast(wakeLast),
    .strobe(strobe), .stopAllowed(stopAllowed), .freqChangeOk(freqChangeOk),
    .clkStopped(clkStopped), .restartReq(restartReq), .cmdReady(cmdReady)
  );
endmodule

// File: rtl/ckstop_guard_chk.sv
module ckstop_guard_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic [2:0] cmdCode,
  input logic       ckeHigh,
  input logic       refreshDue,
  input logic       stopReq,
  input logic       wakeReq,
  input logic       stopAllowed,
  input logic       freqChangeOk,
  input logic       clkStopped,
  input logic       restartReq,
  input logic       cmdReady,
  input logic       ckOut,
  input logic       ckbOut
);
  p_act_window_r1: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdCode == 3'd1 |=> !stopAllowed);
  p_cmd_block_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !stopAllowed);
  p_cke_block_r4: assert property (@(posedge clk) disable iff (!rstN)
    !ckeHigh |-> !stopAllowed);
  p_refresh_block_r5: assert property (@(posedge clk) disable iff (!rstN)
    refreshDue |-> !stopAllowed);
  p_freq_match_r6: assert property (@(posedge clk) disable iff (!rstN)
    freqChangeOk == stopAllowed);
  p_stop_entry_r7: assert property (@(posedge clk) disable iff (!rstN)
    stopReq && stopAllowed |=> clkStopped);
  p_idle_level_r7: assert property (@(posedge clk) disable iff (!rstN)
    clkStopped |-> (!ckOut && ckbOut && !cmdReady));
  p_stop_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    clkStopped && !wakeReq && !refreshDue |=> clkStopped);
  p_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    clkStopped && refreshDue |-> restartReq ##1 !clkStopped);
  p_wake_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkStopped) |-> !cmdReady);
  p_diff_pair_r7: assert property (@(posedge clk) disable iff (!rstN)
    ckbOut == !ckOut);
endmodule

bind ckstop_guard ckstop_guard_chk chk_i (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
  .ckeHigh(ckeHigh), .refreshDue(refreshDue), .stopReq(stopReq),
  .wakeReq(wakeReq), .stopAllowed(stopAllowed), .freqChangeOk(freqChangeOk),
  .clkStopped(clkStopped), .restartReq(restartReq), .cmdReady(cmdReady),
  .ckOut(ckOut), .ckbOut(ckbOut)
);

// File: tb/ckstop_guard_tb_top.sv
module ckstop_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RCD = 3, WRC = 5, RP = 4, RFC = 8, MRD = 2, WAKE = 4;
  localparam int NVEC = 6;
  // {command code, burst delay, burst length, expected low cycles}
  localparam int VEC[NVEC][4] = '{
    '{1, 0, 0, RCD},
    '{3, 0, 0, WRC},
    '{4, 0, 0, RP},
    '{5, 0, 0, RFC},
    '{6, 0, 0, MRD},
    '{2, 2, 4, 6}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdValid = 1'b0, rdBurstActive = 1'b0, ckeHigh = 1'b1;
  logic refreshDue = 1'b0, stopReq = 1'b0, wakeReq = 1'b0;
  logic [2:0] cmdCode = 3'd0;
  logic stopAllowed, freqChangeOk, clkStopped, restartReq, cmdReady, ckOut, ckbOut;
  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ckstop_guard #(.RCD_CYC(RCD), .WR_CYC(WRC), .RP_CYC(RP), .RFC_CYC(RFC),
                 .MRD_CYC(MRD), .WAKE_CYC(WAKE)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .rdBurstActive(rdBurstActive), .ckeHigh(ckeHigh), .refreshDue(refreshDue),
    .stopReq(stopReq), .wakeReq(wakeReq), .stopAllowed(stopAllowed),
    .freqChangeOk(freqChangeOk), .clkStopped(clkStopped), .restartReq(restartReq),
    .cmdReady(cmdReady), .ckOut(ckOut), .ckbOut(ckbOut)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual 1 expected 0");
    summary();
  end

  int lowCnt, prevCk;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R11: reset state
    check("R11 clkStopped", int'(clkStopped), 0);
    check("R11 cmdReady", int'(cmdReady), 1);
    check("R11 restartReq", int'(restartReq), 0);

    // R1 and R2: table of window and read-burst vectors
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      cmdValid = 1'b1;
      cmdCode  = 3'(VEC[v][0]);
      #1;
      check("R3 cmd same cycle", int'(stopAllowed), 0);
      @(posedge clk);
      lowCnt = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        cmdValid = 1'b0;
        cmdCode  = 3'd0;
        rdBurstActive = (k >= VEC[v][1]) && (k < VEC[v][1] + VEC[v][2]);
        #1;
        if (stopAllowed) break;
        lowCnt++;
      end
      check(VEC[v][0] == 2 ? "R2 read burst" : "R1 window", lowCnt, VEC[v][3]);
      check("R6 freqChangeOk", int'(freqChangeOk), int'(stopAllowed));
    end

    // R4: cke low withholds, stop request then ignored (R8)
    @(negedge clk);
    ckeHigh = 1'b0;
    stopReq = 1'b1;
    #1;
    check("R4 cke low", int'(stopAllowed), 0);
    check("R6 freqChangeOk cke", int'(freqChangeOk), 0);
    prevCk = int'(ckOut);
    @(negedge clk);
    #1;
    check("R8 no stop", int'(clkStopped), 0);
    check("R8 clock toggles", int'(ckOut), 1 - prevCk);
    stopReq = 1'b0;
    ckeHigh = 1'b1;

    // R5: refresh due withholds
    @(negedge clk);
    refreshDue = 1'b1;
    #1;
    check("R5 refresh due", int'(stopAllowed), 0);
    @(negedge clk);
    refreshDue = 1'b0;

    // R7: stop entry and idle level
    @(negedge clk);
    stopReq = 1'b1;
    #1;
    check("R7 permission", int'(stopAllowed), 1);
    @(negedge clk);
    stopReq = 1'b0;
    for (int k = 0; k < 3; k++) begin
      #1;
      check("R7 stopped", int'(clkStopped), 1);
      check("R7 ck low", int'(ckOut), 0);
      check("R7 ckb high", int'(ckbOut), 1);
      check("R7 cmdReady", int'(cmdReady), 0);
      @(negedge clk);
    end

    // R10: wake request and hold-off
    wakeReq = 1'b1;
    @(negedge clk);
    wakeReq = 1'b0;
    lowCnt = 0;
    prevCk = int'(ckOut);
    for (int k = 0; k < 20; k++) begin
      #1;
      if (cmdReady) break;
      lowCnt++;
      check("R10 clock runs", int'(clkStopped), 0);
      if (k > 0) check("R10 ck toggles", int'(ckOut), 1 - prevCk);
      prevCk = int'(ckOut);
      @(negedge clk);
    end
    check("R10 wake cycles", lowCnt, WAKE);

    // R9: refresh while stopped forces a restart
    @(negedge clk);
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    #1;
    check("R9 stopped first", int'(clkStopped), 1);
    check("R9 no restart yet", int'(restartReq), 0);
    @(negedge clk);
    refreshDue = 1'b1;
    #1;
    check("R9 restartReq", int'(restartReq), 1);
    @(negedge clk);
    refreshDue = 1'b0;
    #1;
    check("R9 clock restarted", int'(clkStopped), 0);
    check("R9 cmd held", int'(cmdReady), 0);
    repeat (WAKE + 1) @(negedge clk);
    #1;
    check("R9 back to run", int'(cmdReady), 1);

    summary();
  end
endmodule